// File: doc/BRIEF.md
# Framed-Stream Bit Error Counter with Gap Compaction

This block sits behind a wide media-independent receive bus that carries a byte lane and a control flag per lane. It removes all framing overhead from the received words: start and terminate characters, idles, and the seven preamble bytes that follow each start. Overhead may appear at any lane offset, because the bus may be shifted in transit and idle runs may have been stretched or shortened for clock compensation. The remaining payload bytes are packed into a gap-free stream of full bus-width words. A residual store carries partial words across cycles, so one output word may join the tail of one frame to the head of the next.

The packed stream is treated as an unframed serial pattern. It is compared bit by bit against a local PRBS-31 reference that is advanced one whole word per cycle. The reference seeds itself from received bits and tracks lock with hysteresis. While it is locked, it accumulates the number of compared bits and the number of mismatched bits in saturating counters. Words that carry the error character are kept in the stream as placeholders, so that the reference stays in phase. Those bytes are never compared, and each such bus word is counted on a separate counter.

Top module: `cgx_ber_rx`

## Requirements
- R1: A lane with its control flag set and data 8'hFB (start), 8'hFD (terminate) or 8'h07 (idle) is dropped. So are the seven data lanes that follow a start, including when they continue into the next bus word. The start may sit at any lane.
- R2: The remaining bytes leave in arrival order, packed LANES to a word. The earliest byte is in word_data[7:0]. word_vld is high for exactly one cycle per completed word, and bytes not yet forming a full word wait for later payload.
- R3: A lane with its control flag set and data 8'hFE (error) stays in the packed stream as a byte of value 8'hFE, but is never compared or counted in bit_cnt. errword_cnt rises by one for each bus word that holds at least one such lane.
- R4: The reference follows b[n] = b[n-31] XOR b[n-28], with serial order byte 0 first and the LSB first inside each byte. A clean stream produces no mismatches once locked.
- R5: While out of lock, the first packed word without error bytes loads its last 31 bits as the seed. locked rises after LOCK_WORDS further consecutive mismatch-free words.
- R6: For each packed word taken while locked, bit_cnt grows by the number of compared bits and err_cnt by the number of mismatching bits. Nothing is counted while unlocked.
- R7: LOSS_WORDS consecutive locked words, each with at least one mismatch, clear locked. A shorter run of bad words leaves it set.
- R8: bit_cnt, err_cnt and errword_cnt stop at all-ones instead of wrapping.
- R9: After reset, word_vld and locked are 0 and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | LANES*8 | Received bus word, lane 0 in bits [7:0] |
| rx_ctrl | input | LANES | Per-lane control flag |
| word_data | output | LANES*8 | Packed payload word |
| word_vld | output | 1 | word_data holds a new word |
| locked | output | 1 | Reference is in lock |
| bit_cnt | output | CNT_W | Compared bits while locked |
| err_cnt | output | CNT_W | Mismatched bits while locked |
| errword_cnt | output | CNT_W | Bus words carrying an error character |

## Verification
The assertions rely on the input having at most one contiguous overhead run per bus word. This follows from frames that are much longer than a bus word. They also rely on error characters arriving only as whole words. The stimulus builds frames of at least 37 payload bytes with varying idle gaps, so starts land on several lanes. Error characters replace only bus words made entirely of payload. Counter deltas are taken only after idle words have drained the pipeline and the residual store is empty.

// File: rtl/cgx_pkg.sv
package cgx_pkg;
   localparam logic [7:0] CH_IDLE  = 8'h07;
   localparam logic [7:0] CH_START = 8'hFB;
   localparam logic [7:0] CH_TERM  = 8'hFD;
   localparam logic [7:0] CH_ERR   = 8'hFE;
   localparam int         PRE_BYTES = 7;

   typedef enum logic [1:0] {ST_HUNT, ST_ACQ, ST_LOCK} sync_st_t;
endpackage

// File: rtl/cgx_strip.sv
module cgx_strip #(
   parameter int LANES = 8,
   localparam int W  = LANES * 8,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_d,
   input  logic [LANES-1:0] in_c,
   output logic [W-1:0]     c_d,
   output logic [LANES-1:0] c_s,
   output logic [CW-1:0]    c_cnt,
   output logic             ew
);
   import cgx_pkg::*;

   logic [2:0]       pre_q, pre_n;
   logic [LANES-1:0] ovh, skp, cs_n;
   logic [W-1:0]     cd_n;
   logic [CW-1:0]    cnt_n;

   // classify lanes; preamble countdown carries across lanes and words
   always_comb begin
      int pc;
      logic [7:0] byt;
      pc  = int'(pre_q);
      ovh = '0;
      skp = '0;
      for (int l = 0; l < LANES; l++) begin
         byt = in_d[l*8 +: 8];
         if (in_c[l]) begin
            if (byt == CH_ERR) skp[l] = 1'b1;
            else begin
               ovh[l] = 1'b1;
               if (byt == CH_START) pc = PRE_BYTES;
            end
         end else if (pc != 0) begin
            ovh[l] = 1'b1;
            pc = pc - 1;
         end
      end
      pre_n = 3'(pc);
   end

   // single overhead run: bytes below the run stay, bytes above shift down
   always_comb begin
      int first, nov, src;
      first = LANES;
      nov   = 0;
      for (int l = 0; l < LANES; l++) begin
         if (ovh[l]) begin
            nov = nov + 1;
            if (first == LANES) first = l;
         end
      end
      cd_n = '0;
      cs_n = '0;
      for (int i = 0; i < LANES; i++) begin
         src = (i < first) ? i : i + nov;
         if (src < LANES) begin
            cd_n[i*8 +: 8] = in_d[src*8 +: 8];
            cs_n[i]        = skp[src];
         end
      end
      cnt_n = CW'(LANES - nov);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         c_d   <= '0;
         c_s   <= '0;
         c_cnt <= '0;
         ew    <= 1'b0;
      end else begin
         pre_q <= pre_n;
         c_d   <= cd_n;
         c_s   <= cs_n;
         c_cnt <= cnt_n;
         ew    <= |skp;
      end
   end
endmodule

// File: rtl/cgx_pack.sv
module cgx_pack #(
   parameter int LANES = 8,
   localparam int W  = LANES * 8,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     in_d,
   input  logic [LANES-1:0] in_s,
   input  logic [CW-1:0]    in_cnt,
   output logic [W-1:0]     o_d,
   output logic [LANES-1:0] o_s,
   output logic             o_vld
);
   logic [W-1:0]       res_d;
   logic [LANES-1:0]   res_s;
   logic [CW-1:0]      res_cnt;
   logic [2*W-1:0]     cat_d;
   logic [2*LANES-1:0] cat_s;
   logic [CW:0]        tot;

   always_comb begin
      cat_d = {{W{1'b0}}, res_d} | ({{W{1'b0}}, in_d} << {res_cnt, 3'b000});
      cat_s = {{LANES{1'b0}}, res_s} | ({{LANES{1'b0}}, in_s} << res_cnt);
      tot   = {1'b0, res_cnt} + {1'b0, in_cnt};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_d   <= '0;
         res_s   <= '0;
         res_cnt <= '0;
         o_d     <= '0;
         o_s     <= '0;
         o_vld   <= 1'b0;
      end else if (tot >= (CW+1)'(LANES)) begin
         o_d     <= cat_d[W-1:0];
         o_s     <= cat_s[LANES-1:0];
         o_vld   <= 1'b1;
         res_d   <= cat_d[2*W-1:W];
         res_s   <= cat_s[2*LANES-1:LANES];
         res_cnt <= CW'(tot - (CW+1)'(LANES));
      end else begin
         o_vld   <= 1'b0;
         res_d   <= cat_d[W-1:0];
         res_s   <= cat_s[LANES-1:0];
         res_cnt <= CW'(tot);
      end
   end
endmodule

// File: rtl/cgx_prbs_chk.sv
module cgx_prbs_chk #(
   parameter int W          = 64,
   parameter int LOCK_WORDS = 4,
   parameter int LOSS_WORDS = 4,
   parameter int CNT_W      = 64,
   parameter bit POP_PIPE   = 1'b1,
   localparam int PW  = $clog2(W + 1),
   localparam int LKW = $clog2(LOCK_WORDS + 1),
   localparam int LSW = $clog2(LOSS_WORDS + 1),
   localparam int SW  = ((CNT_W > PW) ? CNT_W : PW) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             w_vld,
   input  logic [W-1:0]     w_data,
   input  logic [W-1:0]     w_cmp,
   input  logic             ew_pulse,
   output logic             locked,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [CNT_W-1:0] err_cnt,
   output logic [CNT_W-1:0] ew_cnt
);
   import cgx_pkg::*;

   localparam logic [SW-1:0] CMAX = SW'({CNT_W{1'b1}});

   sync_st_t       st;
   logic [30:0]    ref_q, pred_ref, ref_rx;
   logic [W-1:0]   pred, diff;
   logic [LKW-1:0] good_q;
   logic [LSW-1:0] bad_q;
   logic           bad, full, en_now, c_en;
   logic [W-1:0]   c_d, c_c;

   function automatic logic [PW-1:0] pop(input logic [W-1:0] v);
      logic [PW-1:0] n;
      n = '0;
      for (int i = 0; i < W; i++) n = n + PW'(v[i]);
      return n;
   endfunction

   function automatic logic [CNT_W-1:0] sat(input logic [CNT_W-1:0] c, input logic [PW-1:0] inc);
      logic [SW-1:0] s;
      s = SW'(c) + SW'(inc);
      return (s > CMAX) ? {CNT_W{1'b1}} : CNT_W'(s);
   endfunction

   // advance the reference one word; ref_q[30] is the newest bit
   always_comb begin
      logic [30:0] s;
      logic        nb;
      s = ref_q;
      for (int j = 0; j < W; j++) begin
         nb      = s[0] ^ s[3];
         pred[j] = nb;
         s       = {nb, s[30:1]};
      end
      pred_ref = s;
   end

   assign ref_rx = w_data[W-1 -: 31];
   assign diff   = (w_data ^ pred) & w_cmp;
   assign bad    = |diff;
   assign full   = &w_cmp;
   assign en_now = w_vld && (st == ST_LOCK);
   assign locked = (st == ST_LOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_HUNT;
         ref_q  <= '0;
         good_q <= '0;
         bad_q  <= '0;
      end else if (w_vld) begin
         case (st)
            ST_HUNT: if (full) begin
               ref_q  <= ref_rx;
               good_q <= '0;
               st     <= ST_ACQ;
            end
            ST_ACQ: if (bad) begin
               if (full) begin
                  ref_q  <= ref_rx;
                  good_q <= '0;
               end else st <= ST_HUNT;
            end else begin
               ref_q <= pred_ref;
               if (good_q == LKW'(LOCK_WORDS - 1)) begin
                  st    <= ST_LOCK;
                  bad_q <= '0;
               end else good_q <= good_q + 1'b1;
            end
            ST_LOCK: begin
               ref_q <= pred_ref;
               if (bad) begin
                  if (bad_q == LSW'(LOSS_WORDS - 1)) st <= ST_HUNT;
                  else bad_q <= bad_q + 1'b1;
               end else bad_q <= '0;
            end
            default: st <= ST_HUNT;
         endcase
      end
   end

   generate
      if (POP_PIPE) begin : g_pipe
         logic         q_en;
         logic [W-1:0] q_d, q_c;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_en <= 1'b0;
               q_d  <= '0;
               q_c  <= '0;
            end else begin
               q_en <= en_now;
               q_d  <= diff;
               q_c  <= w_cmp;
            end
         end
         assign c_en = q_en;
         assign c_d  = q_d;
         assign c_c  = q_c;
      end else begin : g_comb
         assign c_en = en_now;
         assign c_d  = diff;
         assign c_c  = w_cmp;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         err_cnt <= '0;
         ew_cnt  <= '0;
      end else begin
         if (c_en) begin
            bit_cnt <= sat(bit_cnt, pop(c_c));
            err_cnt <= sat(err_cnt, pop(c_d));
         end
         ew_cnt <= sat(ew_cnt, PW'(ew_pulse));
      end
   end
endmodule

// File: rtl/cgx_ber_rx.sv
module cgx_ber_rx #(
   parameter int LANES      = 8,
   parameter int LOCK_WORDS = 4,
   parameter int LOSS_WORDS = 4,
   parameter int CNT_W      = 64,
   parameter bit POP_PIPE   = 1'b1,
   localparam int W  = LANES * 8,
   localparam int CW = $clog2(LANES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [W-1:0]     rx_data,
   input  logic [LANES-1:0] rx_ctrl,
   output logic [W-1:0]     word_data,
   output logic             word_vld,
   output logic             locked,
   output logic [CNT_W-1:0] bit_cnt,
   output logic [CNT_W-1:0] err_cnt,
   output logic [CNT_W-1:0] errword_cnt
);
   generate
      if (LANES < 4) begin : g_bad_lanes
         $error("LANES must give at least 31 bits per word");
      end
      if (LOCK_WORDS < 1 || LOSS_WORDS < 1) begin : g_bad_thr
         $error("lock thresholds must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W too small");
      end
   endgenerate

   logic [W-1:0]     s_d;
   logic [LANES-1:0] s_s, p_s;
   logic [CW-1:0]    s_cnt;
   logic             s_ew;
   logic [W-1:0]     cmp;

   cgx_strip #(.LANES(LANES)) strip_i (
      .clk(clk), .rst_n(rst_n), .in_d(rx_data), .in_c(rx_ctrl),
      .c_d(s_d), .c_s(s_s), .c_cnt(s_cnt), .ew(s_ew)
   );

   cgx_pack #(.LANES(LANES)) pack_i (
      .clk(clk), .rst_n(rst_n), .in_d(s_d), .in_s(s_s), .in_cnt(s_cnt),
      .o_d(word_data), .o_s(p_s), .o_vld(word_vld)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_mask
      assign cmp[l*8 +: 8] = {8{~p_s[l]}};
   end

   cgx_prbs_chk #(
      .W(W), .LOCK_WORDS(LOCK_WORDS), .LOSS_WORDS(LOSS_WORDS),
      .CNT_W(CNT_W), .POP_PIPE(POP_PIPE)
   ) chk_i (
      .clk(clk), .rst_n(rst_n), .w_vld(word_vld), .w_data(word_data),
      .w_cmp(cmp), .ew_pulse(s_ew), .locked(locked),
      .bit_cnt(bit_cnt), .err_cnt(err_cnt), .ew_cnt(errword_cnt)
   );
endmodule

// File: rtl/cgx_ber_rx_chk.sv
module cgx_ber_rx_chk #(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             word_vld,
   input logic             locked,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [CNT_W-1:0] err_cnt,
   input logic [CNT_W-1:0] errword_cnt
);
   // R6
   bitcnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt >= $past(bit_cnt));

   // R6
   err_within_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_cnt <= bit_cnt);

   // R5
   lock_on_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(word_vld));

   // R3
   errword_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (errword_cnt - $past(errword_cnt)) <= CNT_W'(1));

   // R6
   count_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt != $past(bit_cnt)) |-> ($past(locked) || $past(locked, 2) || $past(locked, 3)));
endmodule

bind cgx_ber_rx cgx_ber_rx_chk #(.CNT_W(CNT_W)) ber_chk_i (
   .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .locked(locked),
   .bit_cnt(bit_cnt), .err_cnt(err_cnt), .errword_cnt(errword_cnt)
);

// File: tb/cgx_ber_rx_tb_top.sv
module cgx_ber_rx_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 8;
   localparam int W     = LANES * 8;

   typedef struct packed { logic c; logic [7:0] d; logic e; } tok_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [W-1:0]     rx_data;
   logic [LANES-1:0] rx_ctrl;
   logic [W-1:0]     word_data, s_word;
   logic             word_vld, locked, s_vld, s_locked;
   logic [63:0]      bit_cnt, err_cnt, ew_cnt;
   logic [5:0]       s_bits, s_errs, s_ew;

   int checks = 0, errors = 0, ew_exp = 0, err_budget = 0, pre_m = 0;
   tok_t        tx_q[$];
   logic [7:0]  exp_q[$];
   logic [W-1:0] exp_w[$];
   logic [30:0] hist = 31'h5A5A_1234;

   always #(CLK_PERIOD/2) clk = ~clk;

   cgx_ber_rx dut_i (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
      .word_data(word_data), .word_vld(word_vld), .locked(locked),
      .bit_cnt(bit_cnt), .err_cnt(err_cnt), .errword_cnt(ew_cnt)
   );

   cgx_ber_rx #(.CNT_W(6)) sat_i (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
      .word_data(s_word), .word_vld(s_vld), .locked(s_locked),
      .bit_cnt(s_bits), .err_cnt(s_errs), .errword_cnt(s_ew)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   function automatic logic [7:0] gen_byte();
      logic [7:0] b;
      logic nb;
      for (int k = 0; k < 8; k++) begin
         nb   = hist[0] ^ hist[3];
         b[k] = nb;
         hist = {nb, hist[30:1]};
      end
      return b;
   endfunction

   task automatic push_t(input logic c, input logic [7:0] d, input logic e);
      tok_t t;
      t.c = c; t.d = d; t.e = e;
      tx_q.push_back(t);
   endtask

   task automatic add_frame(input int lead, input int len, input logic [7:0] fm, input int nflip, input bit erable);
      logic [7:0] b;
      repeat (lead) push_t(1'b1, 8'h07, 1'b0);
      push_t(1'b1, 8'hFB, 1'b0);
      repeat (6) push_t(1'b0, 8'h55, 1'b0);
      push_t(1'b0, 8'hD5, 1'b0);
      for (int i = 0; i < len; i++) begin
         b = gen_byte();
         if (i < nflip) b = b ^ fm;
         push_t(1'b0, b, erable);
      end
      push_t(1'b1, 8'hFD, 1'b0);
   endtask

   // behavioural model of overhead removal (R1) and packing (R2, R3)
   task automatic model_word(input logic [W-1:0] d, input logic [LANES-1:0] c);
      logic [7:0] b;
      logic [W-1:0] w;
      for (int l = 0; l < LANES; l++) begin
         b = d[l*8 +: 8];
         if (c[l]) begin
            if (b == 8'hFE) exp_q.push_back(b);
            else if (b == 8'hFB) pre_m = 7;
         end else if (pre_m > 0) pre_m--;
         else exp_q.push_back(b);
      end
      while (exp_q.size() >= LANES) begin
         for (int i = 0; i < LANES; i++) w[i*8 +: 8] = exp_q.pop_front();
         exp_w.push_back(w);
      end
   endtask

   task automatic drive(input logic [W-1:0] d, input logic [LANES-1:0] c);
      @(negedge clk);
      rx_data = d;
      rx_ctrl = c;
      model_word(d, c);
   endtask

   task automatic idle_words(input int n);
      repeat (n) drive({LANES{8'h07}}, '1);
   endtask

   task automatic send_all();
      logic [W-1:0] d;
      logic [LANES-1:0] c;
      bit all_e;
      while (tx_q.size() % LANES != 0) push_t(1'b1, 8'h07, 1'b0);
      repeat (4 * LANES) push_t(1'b1, 8'h07, 1'b0);
      while (tx_q.size() >= LANES) begin
         all_e = 1'b1;
         for (int i = 0; i < LANES; i++) begin
            tok_t t;
            t = tx_q.pop_front();
            d[i*8 +: 8] = t.d;
            c[i] = t.c;
            if (!t.e) all_e = 1'b0;
         end
         if (all_e && err_budget > 0) begin
            d = {LANES{8'hFE}};
            c = '1;
            err_budget--;
            ew_exp++;
         end
         drive(d, c);
      end
      idle_words(8);
   endtask

   // packed word compare on every clock (R1, R2)
   always @(negedge clk) begin
      if (rst_n && word_vld) begin
         if (exp_w.size() == 0) chk(1'b0, "R2 unexpected word", word_data, '0);
         else begin
            logic [W-1:0] e;
            e = exp_w.pop_front();
            chk(word_data == e, "R1 R2 packed word", word_data, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      chk(1'b0, "watchdog", 64'd0, 64'd1);
      summary();
   end

   initial begin
      logic [63:0] b0, e0;
      rx_data = {LANES{8'h07}};
      rx_ctrl = '1;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk(word_vld == 1'b0, "R9 word_vld", 64'(word_vld), 0);
      chk(locked == 1'b0, "R9 locked", 64'(locked), 0);
      chk(bit_cnt == 0 && err_cnt == 0 && ew_cnt == 0, "R9 counters", bit_cnt | err_cnt | ew_cnt, 0);
      rst_n = 1'b1;
      idle_words(4);

      // phase A: clean frames, starts on several lanes
      add_frame(3, 40, 8'h00, 0, 1'b0);
      add_frame(5, 41, 8'h00, 0, 1'b0);
      add_frame(10, 47, 8'h00, 0, 1'b0);
      send_all();
      chk(locked == 1'b1, "R5 lock acquired", 64'(locked), 1);
      chk(err_cnt == 0, "R4 clean stream no errors", err_cnt, 0);
      b0 = bit_cnt;
      e0 = err_cnt;

      // phase B: 12 single-bit flips, two error words
      add_frame(1, 37, 8'h01, 12, 1'b0);
      add_frame(6, 43, 8'h00, 0, 1'b1);
      add_frame(0, 48, 8'h00, 0, 1'b0);
      err_budget = 2;
      send_all();
      chk(err_cnt - e0 == 64'd12, "R6 error bit delta", err_cnt - e0, 12);
      chk(bit_cnt - b0 == 64'd896, "R3 R6 compared bit delta", bit_cnt - b0, 896);
      chk(ew_cnt == 64'(ew_exp), "R3 error word count", ew_cnt, 64'(ew_exp));
      chk(locked == 1'b1, "R7 short bad run keeps lock", 64'(locked), 1);

      // phase C: every byte inverted
      add_frame(2, 120, 8'hFF, 120, 1'b0);
      send_all();
      chk(locked == 1'b0, "R7 long bad run drops lock", 64'(locked), 0);
      b0 = bit_cnt;
      idle_words(4);
      chk(bit_cnt == b0, "R6 no counting while unlocked", bit_cnt, b0);

      // phase D: clean traffic, relock
      for (int f = 0; f < 4; f++) add_frame(4 + f, 64, 8'h00, 0, 1'b0);
      send_all();
      chk(locked == 1'b1, "R5 relock after loss", 64'(locked), 1);
      chk(exp_w.size() == 0 && exp_q.size() == 0, "R2 all payload delivered",
          64'(exp_w.size() + exp_q.size()), 0);

      chk(s_bits == 6'h3F, "R8 bit counter saturates", 64'(s_bits), 64'h3F);
      chk(s_errs == 6'h3F, "R8 error counter saturates", 64'(s_errs), 64'h3F);
      chk(s_ew == 6'(ew_exp), "R8 R3 small error word counter", 64'(s_ew), 64'(ew_exp));
      summary();
   end
endmodule